// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves received frames from a byte stream into memory buffers that software has posted in a ring of descriptors. Each descriptor is four 32-bit words, 16 bytes apart: an attribute word, the upper half of the buffer address, the lower half of the buffer address, and a length word whose low half software fills with the buffer capacity. When a frame begins, the engine reads the descriptor at its current ring position. If the hardware-owned flag is set, the engine stores the frame's bytes into the buffer, writes the stored byte count into the upper half of the length word, and then hands the descriptor back to software by rewriting the attribute word with the ownership flag cleared.

A descriptor that software marks as the ring's last one sends the engine back to the programmed ring base; otherwise it steps 16 bytes forward. If the descriptor at the current position still belongs to software, the frame is consumed and thrown away, a drop counter steps, and the ring position stays where it is, so the frame after software re-arms that slot lands there. Memory is reached through a simple port with one-cycle read latency and per-byte write enables, and the frame stream carries start and end markers with a ready handshake.

Top module: `rxd_ring_writer`

## Requirements
- R1: A descriptor occupies 16 bytes: attribute word at offset 0, buffer address upper word at offset 4, lower word at offset 8, length word at offset 12; the engine reads all four at a frame start and never reads and writes memory in the same cycle.
- R2: Attribute bit 31 set means hardware owns the descriptor; if it is clear the frame is accepted and discarded with no memory write, drop_count rises by one at the frame's end, and the ring position is unchanged.
- R3: Frame byte n is written to byte address buffer+n with exactly one byte enable set (lane = address bits 1:0, little-endian), and the buffer address may be unaligned.
- R4: On completion, bits 31:16 of the length word receive the stored byte count and bits 15:0 keep the capacity read from the descriptor.
- R5: The attribute write is the last write for a descriptor and comes in the cycle right after the length write; it clears bit 31, sets bits 9 (first segment) and 8 (last segment), sets bits 17:16 to the error code, and leaves every other bit as read.
- R6: Bytes beyond the capacity are not written; such a frame gets error code 2'b01 and length equal to the capacity, while a frame that fits gets error code 2'b00.
- R7: After a descriptor with attribute bit 30 set the next descriptor is read at the ring base; otherwise at the current address plus 16.
- R8: The ring base is the low ADDR_W bits of {cfg_base_hi, cfg_base_lo}; while cfg_enable is low and no frame is in progress the position reloads to the base and in_ready stays low.
- R9: While idle, bytes without the start marker are accepted and discarded; a byte with the start marker is held until the descriptor has been read.
- R10: After reset drop_count is zero and no memory read or write is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Engine enable; low holds the ring position at the base |
| cfg_base_hi | input | 32 | Ring base address, upper word |
| cfg_base_lo | input | 32 | Ring base address, lower word |
| in_valid | input | 1 | Frame byte present |
| in_ready | output | 1 | Frame byte accepted this cycle when valid |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| mem_rd | output | 1 | Word read request; data returns next cycle |
| mem_we | output | 1 | Write request |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for the write |
| mem_rdata | input | 32 | Read data, one cycle after mem_rd |
| drop_count | output | CNT_W | Frames discarded for lack of an owned descriptor |

## Verification
The bench builds the engine with ADDR_W of 32 and CNT_W of 8, and posts buffers of only 16 bytes, so truncation, exact fill and a single-byte frame all come within short frames. A three-entry ring brings the wrap, a drop at a slot that was released and not re-armed, and the resumed fill of that same slot within a handful of frames; reprogramming the base to a one-entry ring exercises the reload and a wrap onto itself. One buffer starts at an odd address so every byte lane is written.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_RECV, S_DROP, S_WLEN, S_WATTR
  } rxd_state_e;

  localparam int OWN_BIT   = 31;
  localparam int LAST_BIT  = 30;
  localparam int ERR_LO    = 16;
  localparam int FSEG_BIT  = 9;
  localparam int LSEG_BIT  = 8;
  localparam int LEN_W     = 16;
  localparam int DESC_STEP = 16;
  localparam int DESC_WORDS = 4;
  localparam logic [1:0] ERR_NONE  = 2'b00;
  localparam logic [1:0] ERR_TRUNC = 2'b01;
endpackage

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr #(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base,
  input  logic              load,
  input  logic              adv,
  input  logic              wrap,
  output logic [ADDR_W-1:0] cur
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(rxd_pkg::DESC_STEP);

  logic [ADDR_W-1:0] cur_d;
  logic              cur_en;

  always_comb begin
    cur_en = load | adv;
    cur_d  = cur;
    if (load)      cur_d = base;
    else if (wrap) cur_d = base;
    else           cur_d = cur + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur <= '0;
    else if (cur_en) cur <= cur_d;
  end

  // R7: a step lands either on the base or 16 bytes further on
  a_r7_ring_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (cur == $past(base)) || (cur == $past(cur) + STEP));
endmodule

// File: rtl/rxd_fill.sv
module rxd_fill (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     acc,
  input  logic [rxd_pkg::LEN_W-1:0] cap,
  output logic [rxd_pkg::LEN_W-1:0] fill,
  output logic                     store_en,
  output logic                     trunc
);
  logic [rxd_pkg::LEN_W-1:0] fill_d;
  logic                      trunc_d;

  assign store_en = (fill < cap);

  always_comb begin
    fill_d  = fill;
    trunc_d = trunc;
    if (clr) begin
      fill_d  = '0;
      trunc_d = 1'b0;
    end else if (acc) begin
      if (store_en) fill_d  = fill + 1'b1;
      else          trunc_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill  <= '0;
      trunc <= 1'b0;
    end else if (clr | acc) begin
      fill  <= fill_d;
      trunc <= trunc_d;
    end
  end

  // R6: the stored count never passes the capacity
  a_r6_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !clr) |=> (fill <= cap));
endmodule

// File: rtl/rxd_ring_writer.sv
module rxd_ring_writer #(
  parameter int ADDR_W = 64,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic [31:0]       cfg_base_hi,
  input  logic [31:0]       cfg_base_lo,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              mem_rd,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic [31:0]       mem_rdata,
  output logic [CNT_W-1:0]  drop_count
);
  import rxd_pkg::*;

  localparam int FC_W = $clog2(DESC_WORDS + 1);
  localparam logic [FC_W-1:0] FC_LAST = FC_W'(DESC_WORDS);

  rxd_state_e        state, state_d;
  logic [FC_W-1:0]   fcnt;
  logic [31:0]       attr_q, bhi_q, blo_q;
  logic [LEN_W-1:0]  cap_q;
  logic [CNT_W-1:0]  drop_q;

  logic [63:0]       base_w, buf_w;
  logic [ADDR_W-1:0] cur, buf_a, byte_a;
  logic [LEN_W-1:0]  fill;
  logic              store_en, trunc, acc, frame_end;
  logic [31:0]       attr_out;

  assign base_w    = {cfg_base_hi, cfg_base_lo};
  assign buf_w     = {bhi_q, blo_q};
  assign buf_a     = buf_w[ADDR_W-1:0];
  assign byte_a    = buf_a + ADDR_W'(fill);
  assign acc       = in_valid & in_ready;
  assign frame_end = acc & in_eof;
  assign drop_count = drop_q;

  rxd_ring_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk  (clk),
    .rst_n(rst_n),
    .base (base_w[ADDR_W-1:0]),
    .load (!cfg_enable && state == S_IDLE),
    .adv  (state == S_WATTR),
    .wrap (attr_q[LAST_BIT]),
    .cur  (cur)
  );

  rxd_fill u_fill (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (state == S_FETCH),
    .acc     (state == S_RECV && acc),
    .cap     (cap_q),
    .fill    (fill),
    .store_en(store_en),
    .trunc   (trunc)
  );

  always_comb begin
    attr_out                        = attr_q;
    attr_out[OWN_BIT]               = 1'b0;
    attr_out[ERR_LO+1:ERR_LO]       = trunc ? ERR_TRUNC : ERR_NONE;
    attr_out[FSEG_BIT]              = 1'b1;
    attr_out[LSEG_BIT]              = 1'b1;
  end

  // next state
  always_comb begin
    state_d = state;
    case (state)
      S_IDLE:  if (cfg_enable && in_valid && in_sof) state_d = S_FETCH;
      S_FETCH: if (fcnt == FC_LAST) state_d = attr_q[OWN_BIT] ? S_RECV : S_DROP;
      S_RECV:  if (frame_end) state_d = S_WLEN;
      S_DROP:  if (frame_end) state_d = S_IDLE;
      S_WLEN:  state_d = S_WATTR;
      S_WATTR: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // memory and stream outputs
  always_comb begin
    in_ready  = 1'b0;
    mem_rd    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur;
    mem_wdata = '0;
    mem_be    = '0;
    case (state)
      S_IDLE:  in_ready = cfg_enable && !in_sof;
      S_FETCH: begin
        mem_rd   = (fcnt < FC_LAST);
        mem_addr = cur + ADDR_W'({fcnt[1:0], 2'b00});
      end
      S_RECV: begin
        in_ready = 1'b1;
        if (in_valid && store_en) begin
          mem_we    = 1'b1;
          mem_addr  = {byte_a[ADDR_W-1:2], 2'b00};
          mem_wdata = {4{in_data}};
          mem_be    = 4'b0001 << byte_a[1:0];
        end
      end
      S_DROP:  in_ready = 1'b1;
      S_WLEN: begin
        mem_we    = 1'b1;
        mem_addr  = cur + ADDR_W'(12);
        mem_wdata = {fill, cap_q};
        mem_be    = 4'hF;
      end
      S_WATTR: begin
        mem_we    = 1'b1;
        mem_wdata = attr_out;
        mem_be    = 4'hF;
      end
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      fcnt   <= '0;
      attr_q <= '0;
      bhi_q  <= '0;
      blo_q  <= '0;
      cap_q  <= '0;
      drop_q <= '0;
    end else begin
      state <= state_d;
      fcnt  <= (state == S_FETCH) ? fcnt + 1'b1 : '0;
      if (state == S_FETCH) begin
        case (fcnt)
          FC_W'(1): attr_q <= mem_rdata;
          FC_W'(2): bhi_q  <= mem_rdata;
          FC_W'(3): blo_q  <= mem_rdata;
          FC_W'(4): cap_q  <= mem_rdata[LEN_W-1:0];
          default: ;
        endcase
      end
      if (state == S_DROP && frame_end) drop_q <= drop_q + 1'b1;
    end
  end

  // R1: never read and write in one cycle
  a_r1_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_we));

  // R3: a partial write touches exactly one byte lane
  a_r3_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_be != 4'hF) |-> ($countones(mem_be) == 1));

  // R5: release write follows the length write directly
  a_r5_len_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_be == 4'hF && mem_addr[3:0] == 4'h0) |->
      $past(mem_we && mem_be == 4'hF && mem_addr[3:0] == 4'hC));

  // R5: the release write hands ownership back
  a_r5_release_clears_own: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_be == 4'hF && mem_addr[3:0] == 4'h0) |-> !mem_wdata[OWN_BIT]);

  // R2: the drop count only moves at an accepted frame end
  a_r2_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count != $past(drop_count)) |-> $past(in_valid && in_ready && in_eof));

  // R8: nothing is accepted while disabled and idle
  a_r8_ready_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_enable && state == S_IDLE) |-> !in_ready);
endmodule

// File: tb/sim_rxd_ring_writer.sv
module sim_rxd_ring_writer;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_enable;
  logic [31:0] cfg_base_hi, cfg_base_lo;
  logic in_valid, in_ready, in_sof, in_eof;
  logic [7:0] in_data;
  logic mem_rd, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic [CNT_W-1:0] drop_count;

  always #(CLK_P/2) clk = ~clk;

  rxd_ring_writer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
    .cfg_base_hi(cfg_base_hi), .cfg_base_lo(cfg_base_lo),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata),
    .drop_count(drop_count)
  );

  // memory model: 4 KiB, one-cycle read latency
  logic [31:0] mem [0:1023];
  always @(posedge clk) begin
    if (mem_we)
      for (int l = 0; l < 4; l++)
        if (mem_be[l]) mem[mem_addr[11:2]][8*l +: 8] = mem_wdata[8*l +: 8];
    if (mem_rd) mem_rdata <= mem[mem_addr[11:2]];
  end

  function automatic logic [7:0] rdb(input logic [31:0] a);
    return mem[a[11:2]][8*a[1:0] +: 8];
  endfunction

  int total = 0;
  int bad   = 0;
  int wr_cnt = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0]  desc;
    logic [31:0]  attr;
    logic [31:0]  lenw;
    logic [31:0]  bufa;
    logic [7:0]   n;
    logic [511:0] bytes;
  } exp_t;
  exp_t q[$];

  // monitor: each release write is compared against the next expected item
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      wr_cnt++;
      if (mem_be == 4'hF && mem_addr[3:0] == 4'h0) begin
        if (q.size() == 0) begin
          chk(1'b0, "R2", {32'h0, mem_addr}, 64'h0);
        end else begin
          exp_t e;
          bit ok;
          e = q.pop_front();
          chk(mem_addr == e.desc, "R7", {32'h0, mem_addr}, {32'h0, e.desc});
          chk(mem_wdata == e.attr, "R5", {32'h0, mem_wdata}, {32'h0, e.attr});
          chk(mem[(e.desc + 12) >> 2] == e.lenw, "R4",
              {32'h0, mem[(e.desc + 12) >> 2]}, {32'h0, e.lenw});
          ok = 1'b1;
          for (int k = 0; k < int'(e.n); k++)
            if (rdb(e.bufa + k) != e.bytes[8*k +: 8]) ok = 1'b0;
          chk(ok, "R3", {56'h0, e.n}, {56'h0, e.n});
        end
      end
    end
  end

  task automatic arm(input logic [31:0] da, input logic last, input logic [31:0] bufa,
                     input logic [15:0] cap);
    mem[da >> 2]       = 32'h8003_0020 | (32'(last) << 30);
    mem[(da >> 2) + 1] = 32'h0;
    mem[(da >> 2) + 2] = bufa;
    mem[(da >> 2) + 3] = {16'hBEEF, cap};
    for (int k = 0; k < 16; k++) mem[(bufa >> 2) + k] = 32'h0;
  endtask

  task automatic put(input logic [7:0] d, input logic s, input logic e);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic drive(input int n, input logic [7:0] seed, input int junk);
    for (int j = 0; j < junk; j++) put(8'hEE, 1'b0, 1'b0);
    for (int k = 0; k < n; k++) put(seed + 8'(k), k == 0, k == n - 1);
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  // driver: push the expected release, then send the frame
  task automatic send(input logic [31:0] da, input int n, input logic [7:0] seed, input int junk);
    exp_t e;
    logic [31:0] a0;
    logic [15:0] cap;
    int st;
    a0   = mem[da >> 2];
    cap  = mem[(da >> 2) + 3][15:0];
    st   = (n > int'(cap)) ? int'(cap) : n;
    e.desc  = da;
    e.attr  = (a0 & ~32'h8003_0000) | ((n > int'(cap)) ? 32'h0001_0000 : 32'h0) | 32'h0000_0300;
    e.lenw  = {16'(st), cap};
    e.bufa  = mem[(da >> 2) + 2];
    e.n     = 8'(st);
    e.bytes = '0;
    for (int k = 0; k < st; k++) e.bytes[8*k +: 8] = seed + 8'(k);
    q.push_back(e);
    drive(n, seed, junk);
  endtask

  task automatic wait_q();
    for (int i = 0; i < 200 && q.size() != 0; i++) @(negedge clk);
    chk(q.size() == 0, "R5", 64'(q.size()), 64'h0);
    repeat (3) @(negedge clk);
  endtask

  task automatic send_drop(input logic [31:0] da, input int n, input logic [CNT_W-1:0] exp_cnt);
    int w0;
    logic [31:0] a0;
    w0 = wr_cnt;
    a0 = mem[da >> 2];
    drive(n, 8'h77, 0);
    repeat (6) @(negedge clk);
    chk(drop_count == exp_cnt, "R2", 64'(drop_count), 64'(exp_cnt));
    chk(wr_cnt == w0, "R2", 64'(wr_cnt), 64'(w0));
    chk(mem[da >> 2] == a0, "R2", {32'h0, mem[da >> 2]}, {32'h0, a0});
  endtask

  initial begin
    #(CLK_P * 150000);
    chk(1'b0, "watchdog", 64'h0, 64'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    rst_n = 1'b0; cfg_enable = 1'b0;
    cfg_base_hi = 32'h0; cfg_base_lo = 32'h100;
    in_valid = 1'b0; in_data = 8'h0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(drop_count == 0, "R10", 64'(drop_count), 64'h0);
    chk(!mem_rd && !mem_we, "R10", {62'h0, mem_rd, mem_we}, 64'h0);
    // R8: disabled, start byte presented, nothing accepted
    in_valid = 1'b1; in_sof = 1'b1; in_data = 8'h11;
    #1;
    chk(!in_ready, "R8", 64'(in_ready), 64'h0);
    repeat (2) @(negedge clk);
    chk(!mem_rd, "R8", 64'(mem_rd), 64'h0);
    in_valid = 1'b0; in_sof = 1'b0;

    arm(32'h100, 1'b0, 32'h400, 16'd16);
    arm(32'h110, 1'b0, 32'h440, 16'd16);
    arm(32'h120, 1'b1, 32'h480, 16'd16);
    cfg_enable = 1'b1;
    @(negedge clk);

    send(32'h100, 5, 8'h10, 2);   // R9: two stray bytes first; R1 layout
    wait_q();
    send(32'h110, 16, 8'h40, 0);  // exact fill, R4
    wait_q();
    send(32'h120, 20, 8'h80, 0);  // R6 truncation
    wait_q();
    chk(rdb(32'h490) == 8'h00, "R6", 64'(rdb(32'h490)), 64'h0);

    // R7 wrap lands on slot 0, which software has not re-armed: R2 drop
    send_drop(32'h100, 4, 8'd1);
    arm(32'h100, 1'b0, 32'h400, 16'd16);
    send(32'h100, 1, 8'hA5, 0);   // single-byte frame, same slot after stall
    wait_q();
    send_drop(32'h110, 3, 8'd2);
    arm(32'h110, 1'b0, 32'h440, 16'd16);
    send(32'h110, 3, 8'hC0, 0);
    wait_q();
    // R3: unaligned buffer
    arm(32'h120, 1'b1, 32'h4C1, 16'd16);
    send(32'h120, 6, 8'h20, 0);
    wait_q();

    // R8: new base, one-entry ring wrapping onto itself (R7)
    @(negedge clk);
    cfg_enable = 1'b0;
    cfg_base_lo = 32'h200;
    repeat (2) @(negedge clk);
    arm(32'h200, 1'b1, 32'h500, 16'd8);
    cfg_enable = 1'b1;
    send(32'h200, 7, 8'h30, 0);
    wait_q();
    arm(32'h200, 1'b1, 32'h500, 16'd8);
    send(32'h200, 9, 8'h50, 1);   // truncated at capacity 8
    wait_q();
    chk(rdb(32'h508) == 8'h00, "R6", 64'(rdb(32'h508)), 64'h0);
    chk(drop_count == 8'd2, "R2", 64'(drop_count), 64'h2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule